// File: doc/BRIEF.md
# 32-bit Add/Subtract Unit with Condition Flags

This block performs two's-complement integer arithmetic on two operands and records four condition flags describing the outcome: Negative, Zero, Carry and oVerflow. Each operation presented with a valid strobe picks one of four kinds. It can add the operands, subtract the second from the first, compare them, or negate the first operand. Subtraction is carried out by adding the bitwise inverse of the subtrahend with a carry-in of one. The flags are computed identically whether the caller treats the operands as signed or unsigned. The caller picks which flags it reads.

A result and its write enable appear on the clock edge after the valid strobe. A set-flags request travels with each operation and decides whether the flag register takes the new values. Compare is the exception: it always updates the flags and never raises the write enable. The flags are read as the top four bits of a 32-bit status word.

Top module: `arith_flag_unit`

## Requirements
- R1: Operation code 2'b00 (add) writes a + b modulo 2^32; C is 1 exactly when the true sum needs a 33rd bit.
- R2: Operation code 2'b01 (subtract) writes a + ~b + 1; C is 1 exactly when no borrow occurs, that is when a >= b as unsigned numbers.
- R3: When the flags update, N equals bit 31 of the result, and Z is 1 only when all 32 result bits are zero.
- R4: For add, V is 1 when both operands share a sign bit and the result's sign bit differs from it.
- R5: For subtract and compare, V is 1 when the operands' sign bits differ and the result's sign bit differs from that of operand a.
- R6: Add, subtract and negate update the flags only when the set-flags input is 1 with the valid strobe; otherwise all four flags keep their previous values.
- R7: Operation code 2'b10 (compare) evaluates a − b, leaves the result output and write enable untouched (write enable 0), and always updates all four flags regardless of set-flags.
- R8: Operation code 2'b11 (negate) writes ~a + 1, and its flags are those of 0 − a. Negating 0x80000000 yields 0x80000000 with N = 1 and V = 1. Negating 0 yields C = 1 and Z = 1.
- R9: The status word carries N, Z, C, V at bits 31, 30, 29, 28 respectively; bits 27 to 0 read as 0.
- R10: The result, write enable and flag update take effect on the first rising edge after the strobed inputs. The write enable is 0 in any cycle not preceded by a valid non-compare operation. The result output holds its last written value.
- R11: Reset clears all four flags, the result and the write enable to 0. Reset asserts asynchronously and is released synchronously to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code: 00 add, 01 subtract, 10 compare, 11 negate |
| in_setf | input | 1 | Set-flags request for add, subtract and negate |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand (unused by negate) |
| out_result | output | 32 | Registered result of the last writing operation |
| out_wr_en | output | 1 | One-cycle result-write enable |
| out_status | output | 32 | Status word with the flags in bits 31..28 |

## Verification
The embedded properties assume that in_valid, in_op, in_setf and both operands hold known values in every cycle after reset is released. They also assume those inputs change only between clock edges, since each property compares outputs against values sampled one edge earlier. The bench keeps to this by driving every input from a single task on the falling clock edge. It holds all inputs at defined levels during reset, and it returns in_valid to 0 in idle cycles rather than leaving it undriven. Negate is issued with an arbitrary second operand to show that operand is ignored.

// File: rtl/arith_pkg.sv
`timescale 1ns/1ps
package arith_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_NEG = 2'b11
  } arith_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int FLAG_COUNT = 4;

endpackage

// File: rtl/arith_rst_sync.sv
`timescale 1ns/1ps
module arith_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/arith_addsub.sv
`timescale 1ns/1ps
module arith_addsub
  import arith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  arith_op_e        op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             is_sub,
  output logic             lhs_msb,
  output logic             rhs_msb
);

  localparam int XW = WIDTH + 1;

  logic [WIDTH-1:0] lhs;
  logic [WIDTH-1:0] rhs;
  logic [WIDTH-1:0] rhs_eff;
  logic [XW-1:0]    wide;

  // Negate is folded into subtract as 0 - a.
  always_comb begin
    lhs    = opa;
    rhs    = opb;
    is_sub = 1'b1;
    unique case (op)
      OP_ADD: is_sub = 1'b0;
      OP_SUB: ;
      OP_CMP: ;
      OP_NEG: begin
        lhs = '0;
        rhs = opa;
      end
      default: ;
    endcase
  end

  assign rhs_eff = is_sub ? ~rhs : rhs;
  assign wide    = {1'b0, lhs} + {1'b0, rhs_eff} + {{WIDTH{1'b0}}, is_sub};
  assign sum     = wide[WIDTH-1:0];
  assign carry   = wide[XW-1];
  assign lhs_msb = lhs[WIDTH-1];
  assign rhs_msb = rhs[WIDTH-1];

endmodule

// File: rtl/arith_flag_eval.sv
`timescale 1ns/1ps
module arith_flag_eval
  import arith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carry,
  input  logic             is_sub,
  input  logic             lhs_msb,
  input  logic             rhs_msb,
  output nzcv_t            flags
);

  logic res_msb;
  logic sign_flip;
  logic same_sign;

  assign res_msb   = sum[WIDTH-1];
  assign sign_flip = res_msb ^ lhs_msb;
  assign same_sign = ~(lhs_msb ^ rhs_msb);

  always_comb begin
    flags.n = res_msb;
    flags.z = ~|sum;
    flags.c = carry;
    flags.v = sign_flip & (is_sub ? ~same_sign : same_sign);
  end

endmodule

// File: rtl/arith_flag_unit.sv
`timescale 1ns/1ps
module arith_flag_unit
  import arith_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic             in_setf,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic [WIDTH-1:0] out_result,
  output logic             out_wr_en,
  output logic [WIDTH-1:0] out_status
);

  localparam int PAD_W = WIDTH - FLAG_COUNT;
  localparam int BIT_N = WIDTH - 1;
  localparam int BIT_Z = WIDTH - 2;
  localparam int BIT_C = WIDTH - 3;
  localparam int BIT_V = WIDTH - 4;

  logic             rst_sync_n;
  arith_op_e        op;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             is_sub;
  logic             lhs_msb;
  logic             rhs_msb;
  nzcv_t            flags_new;

  logic [WIDTH-1:0] result_d, result_q;
  logic             wr_d, wr_q;
  nzcv_t            flags_d, flags_q;
  logic             load_flags;
  logic             load_result;

  assign op = arith_op_e'(in_op);

  arith_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  arith_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op      (op),
    .opa     (in_a),
    .opb     (in_b),
    .sum     (sum),
    .carry   (carry),
    .is_sub  (is_sub),
    .lhs_msb (lhs_msb),
    .rhs_msb (rhs_msb)
  );

  arith_flag_eval #(.WIDTH(WIDTH)) u_flag_eval (
    .sum     (sum),
    .carry   (carry),
    .is_sub  (is_sub),
    .lhs_msb (lhs_msb),
    .rhs_msb (rhs_msb),
    .flags   (flags_new)
  );

  // Next-state logic
  always_comb begin
    load_flags  = in_valid & (in_setf | (op == OP_CMP));
    load_result = in_valid & (op != OP_CMP);
    result_d    = load_result ? sum : result_q;
    wr_d        = load_result;
    flags_d     = load_flags ? flags_new : flags_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
      wr_q     <= 1'b0;
      flags_q  <= '0;
    end else begin
      result_q <= result_d;
      wr_q     <= wr_d;
      flags_q  <= flags_d;
    end
  end

  assign out_result = result_q;
  assign out_wr_en  = wr_q;
  assign out_status = {flags_q, {PAD_W{1'b0}}};

  // R7: compare never raises the write enable
  p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op == OP_CMP) |=> !out_wr_en);

  // R7: compare always refreshes Z as operand equality
  p_cmp_zero_eq_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op == OP_CMP) |=> (out_status[BIT_Z] == ($past(in_a) == $past(in_b))));

  // R6: flags stay put when no update is requested
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(in_valid && (in_setf || in_op == OP_CMP)) |=> $stable(out_status));

  // R10: write enable follows a valid non-compare operation
  p_wr_follow_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op != OP_CMP) |=> out_wr_en);

  // R10: no write without a strobe
  p_no_wr_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_wr_en);

  // R3: N and Z track the written result
  p_nz_match_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_setf && in_op != OP_CMP) |=>
      (out_status[BIT_N] == out_result[WIDTH-1] && out_status[BIT_Z] == (out_result == '0)));

  // R2: subtract carry means no borrow
  p_sub_carry_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_setf && in_op == OP_SUB) |=> (out_status[BIT_C] == ($past(in_a) >= $past(in_b))));

  // R4: add overflow only for like-signed operands whose sum flips sign
  p_add_ovf_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_setf && in_op == OP_ADD && in_a[WIDTH-1] == in_b[WIDTH-1]) |=>
      (out_status[BIT_V] == (out_result[WIDTH-1] != $past(in_a[WIDTH-1]))));

  // R4: unlike-signed add never overflows
  p_add_no_ovf_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_setf && in_op == OP_ADD && in_a[WIDTH-1] != in_b[WIDTH-1]) |=> !out_status[BIT_V]);

endmodule

// File: tb/arith_flag_unit_bench.sv
`timescale 1ns/1ps
module arith_flag_unit_bench;

  localparam int W = 32;

  typedef struct {
    logic          wr;
    logic [W-1:0]  res;
    logic [3:0]    fl;
    string         req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_op;
  logic         in_setf;
  logic [W-1:0] in_a, in_b;
  logic [W-1:0] out_result;
  logic         out_wr_en;
  logic [W-1:0] out_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  item_t        sb_q[$];
  logic [3:0]   m_flags;
  logic [W-1:0] m_res;

  always #2 clk = ~clk;

  arith_flag_unit u_arith_flag_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_setf    (in_setf),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_result (out_result),
    .out_wr_en  (out_wr_en),
    .out_status (out_status)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic sf, input string req);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic         c, v;
    longint       s;
    item_t        it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_setf = sf;
    case (op)
      2'b00: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[W-1:0]; c = wide[W];
        s = longint'($signed(a)) + longint'($signed(b));
      end
      2'b11: begin
        r = -a; c = (a == 0);
        s = 64'sd0 - longint'($signed(a));
      end
      default: begin
        r = a - b; c = (a >= b);
        s = longint'($signed(a)) - longint'($signed(b));
      end
    endcase
    v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    if (sf || op == 2'b10) m_flags = {r[W-1], (r == 0), c, v};
    if (op != 2'b10) m_res = r;
    it.wr = (op != 2'b10); it.res = m_res; it.fl = m_flags; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b0;
    it.wr = 1'b0; it.res = m_res; it.fl = m_flags; it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compares one edge after each driven cycle
  always begin
    item_t it;
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      chk(it.req, "wr_en",  {{(W-1){1'b0}}, out_wr_en}, {{(W-1){1'b0}}, it.wr});
      chk(it.req, "result", out_result, it.res);
      chk(it.req, "status", out_status, {it.fl, {(W-4){1'b0}}}); // R9 layout
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_setf = 1'b0; in_a = '0; in_b = '0;
    m_flags = 4'b0; m_res = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11", "status", out_status, '0);
    chk("R11", "wr_en", {31'b0, out_wr_en}, '0);
    chk("R11", "result", out_result, '0);

    send(2'b00, 32'hC000_0000, 32'h7000_0000, 1'b1, "R1");
    send(2'b00, 32'hC000_0000, 32'h4000_0000, 1'b1, "R3");
    send(2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, "R4");
    send(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b1, "R4");
    send(2'b00, 32'h0000_0003, 32'h0000_0004, 1'b0, "R6");
    send(2'b01, 32'h0000_0005, 32'h0000_0003, 1'b1, "R2");
    send(2'b01, 32'h0000_0003, 32'h0000_0005, 1'b1, "R2");
    send(2'b01, 32'h1234_5678, 32'h1234_5678, 1'b1, "R2");
    send(2'b01, 32'h8000_0000, 32'h0000_0001, 1'b1, "R5");
    send(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
    send(2'b01, 32'h0000_0009, 32'h0000_0001, 1'b0, "R6");
    idle("R10");
    send(2'b10, 32'h0000_0002, 32'h0000_0002, 1'b0, "R7");
    send(2'b10, 32'h8000_0000, 32'h0000_0001, 1'b0, "R7");
    send(2'b10, 32'h0000_0001, 32'h0000_0002, 1'b1, "R7");
    send(2'b11, 32'h0000_0007, 32'hDEAD_BEEF, 1'b1, "R8");
    send(2'b11, 32'h8000_0000, 32'h0000_0000, 1'b1, "R8");
    send(2'b11, 32'h0000_0000, 32'h1111_1111, 1'b1, "R8");
    send(2'b11, 32'h0000_0005, 32'h0000_0000, 1'b0, "R6");
    idle("R10");
    idle("R10");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(3));
      send(op, $urandom, (i % 5 == 0) ? 32'h8000_0000 : $urandom, 1'($urandom_range(1)),
           (op == 2'b00) ? "R1" : (op == 2'b01) ? "R5" : (op == 2'b10) ? "R7" : "R8");
      if (i % 7 == 0) idle("R10");
    end
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    // R11: reset in mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "status after reset", out_status, '0);
    chk("R11", "result after reset", out_result, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule